// File: doc/BRIEF.md
# Falling-Edge Phase/Frequency Detector with Pump Gating

This block compares two divided clocks inside a frequency-synthesis loop: the divided oscillator signal and the divided reference signal. Both signals are sampled on a fast sample clock. When the oscillator falls first, the block drives a pump-up request. When the reference falls first, it drives a pump-down request. In both cases the request lasts exactly as many sample cycles as separate the two falling edges. Rising edges play no part.

Software control bits shape what leaves the block:
- A disable bit silences both requests and keeps the pump output enable low, so the pump floats.
- A level-select bit picks the higher of two pump currents while a request is active.
- A disconnect bit detaches the tuning amplifier.

A lock flag rises after a run of comparisons in which the two edges stayed within one sample cycle of each other.

Top module: `pfd_negedge`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, up, dn, pump_oe, pump_hi and locked are 0.
- R2: If osc_div falls d cycles (d ≥ 1) before ref_div, up is high for exactly d consecutive cycles. It starts the cycle after the sample that saw osc_div low.
- R3: If ref_div falls d cycles (d ≥ 1) before osc_div, dn is high for exactly d consecutive cycles. It starts the cycle after the sample that saw ref_div low.
- R4: When both inputs fall in the same sample cycle, neither up nor dn is asserted. Once both internal edge flags are set, they clear together on the following cycle.
- R5: While pump_off is 1, up, dn and pump_oe stay 0 whatever the phase relation.
- R6: pump_oe is 1 exactly when up or dn is 1.
- R7: pump_hi equals cur_hi while pump_oe is 1, and is 0 otherwise.
- R8: amp_en is the inverse of amp_disc.
- R9: locked becomes 1 once LOCK_N (default 8) consecutive comparisons have had a one-sided pulse width of at most one cycle.
- R10: A comparison whose one-sided width is two or more cycles clears locked. This happens in the cycle that follows the completion of that comparison.
- R11: Rising edges on either input never start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_div | input | 1 | Divided oscillator signal, synchronous to clk |
| ref_div | input | 1 | Divided reference signal, synchronous to clk |
| pump_off | input | 1 | 1 forces the pump off (floating) |
| cur_hi | input | 1 | 1 selects the higher pump current |
| amp_disc | input | 1 | 1 disconnects the tuning amplifier |
| up | output | 1 | Pump-up request (source current) |
| dn | output | 1 | Pump-down request (sink current) |
| pump_oe | output | 1 | Pump output enable; 0 means high impedance |
| pump_hi | output | 1 | Higher current level active |
| amp_en | output | 1 | Tuning amplifier connected |
| locked | output | 1 | Lock indication |

## Verification
Corruption of the edge flags appears within one sample cycle, as a request that is too long, too short or on the wrong side. The scoreboard compares every pulse's direction, width and current level against what the driver predicted. A stuck flag shows as a pulse that never ends, and so as a mismatch at the next comparison. A faulty lock counter shows only once a run of comparisons finishes, so the bench checks locked after the seventh and eighth tight comparison and right after a wide one.

// File: rtl/pfd_negedge.sv
module pfd_negedge #(
  parameter int LOCK_N = 8,
  parameter int WCNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_div,
  input  logic ref_div,
  input  logic pump_off,
  input  logic cur_hi,
  input  logic amp_disc,
  output logic up,
  output logic dn,
  output logic pump_oe,
  output logic pump_hi,
  output logic amp_en,
  output logic locked
);
  localparam int CW = $clog2(LOCK_N + 1);

  logic osc_q, ref_q, up_f, dn_f;
  logic [WCNT_W-1:0] wcnt;
  logic [CW-1:0] good;

  wire fall_osc = osc_q & ~osc_div;
  wire fall_ref = ref_q & ~ref_div;
  wire both     = up_f & dn_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      ref_q <= 1'b0;
      up_f  <= 1'b0;
      dn_f  <= 1'b0;
      wcnt  <= '0;
      good  <= '0;
    end else begin
      osc_q <= osc_div;
      ref_q <= ref_div;
      if (both) begin
        up_f <= 1'b0;
        dn_f <= 1'b0;
        wcnt <= '0;
        if (wcnt <= WCNT_W'(1)) begin
          if (good != CW'(LOCK_N)) good <= good + 1'b1;
        end else begin
          good <= '0;
        end
      end else begin
        if (fall_osc) up_f <= 1'b1;
        if (fall_ref) dn_f <= 1'b1;
        if ((up_f ^ dn_f) && (wcnt != '1)) wcnt <= wcnt + 1'b1;
      end
    end
  end

  assign up      = up_f & ~dn_f & ~pump_off;
  assign dn      = dn_f & ~up_f & ~pump_off;
  assign pump_oe = up | dn;
  assign pump_hi = cur_hi & pump_oe;
  assign amp_en  = ~amp_disc;
  assign locked  = (good == CW'(LOCK_N));

  assert_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    both |=> (!up_f && !dn_f));

  assert_up_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_osc && !fall_ref && !up_f && !dn_f && !pump_off) |=> up);

  assert_up_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_f && !dn_f && !fall_ref) |=> up_f);

  assert_lock_on_compare_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(both));
endmodule

// File: tb/pfd_negedge_tb.sv
module pfd_negedge_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct { int dir; int width; int hi; } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_div = 1'b1, ref_div = 1'b1;
  logic pump_off = 1'b0, cur_hi = 1'b0, amp_disc = 1'b0;
  logic up, dn, pump_oe, pump_hi, amp_en, locked;

  int n_chk = 0, n_bad = 0;
  item_t exp_q[$];
  int run_dir = 0, run_w = 0, run_hi = 0;

  pfd_negedge dut_i (
    .clk(clk), .rst_n(rst_n), .osc_div(osc_div), .ref_div(ref_div),
    .pump_off(pump_off), .cur_hi(cur_hi), .amp_disc(amp_disc),
    .up(up), .dn(dn), .pump_oe(pump_oe), .pump_hi(pump_hi),
    .amp_en(amp_en), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic close_run();
    item_t e;
    if (exp_q.size() == 0) begin
      check("R5/R11 unexpected pulse", run_dir, 0);
    end else begin
      e = exp_q.pop_front();
      check("R2/R3 direction", run_dir, e.dir);
      check("R2/R3 width", run_w, e.width);
      check("R7 level", run_hi, e.hi);
    end
    run_dir = 0;
    run_w = 0;
  endtask

  // lead: 1 oscillator first, 2 reference first, 0 coincident
  task automatic compare(int lead, int d);
    if (lead != 0 && d > 0 && !pump_off) exp_q.push_back('{lead, d, int'(cur_hi)});
    @(negedge clk);
    if (lead == 0) begin osc_div = 0; ref_div = 0; end
    else if (lead == 1) osc_div = 0;
    else ref_div = 0;
    if (lead != 0) begin
      repeat (d) @(negedge clk);
      osc_div = 0; ref_div = 0;
    end
    repeat (8) @(negedge clk);
    osc_div = 1;
    repeat (3) @(negedge clk);
    ref_div = 1;
    repeat (8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int cur;
      cur = up ? 1 : (dn ? 2 : 0);
      if (pump_oe != (up | dn)) check("R6 pump_oe", pump_oe, up | dn);
      if (!pump_oe && pump_hi) check("R7 level while idle", pump_hi, 0);
      if (cur != 0) begin
        if (run_dir == cur) run_w++;
        else begin
          if (run_dir != 0) close_run();
          run_dir = cur; run_w = 1; run_hi = pump_hi;
        end
      end else if (run_dir != 0) close_run();
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 up", up, 0); check("R1 dn", dn, 0);
    check("R1 pump_oe", pump_oe, 0); check("R1 locked", locked, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 pump_hi", pump_hi, 0);
    check("R8 amp_en", amp_en, 1);
    amp_disc = 1; #1; check("R8 amp_en off", amp_en, 0);
    amp_disc = 0;

    compare(1, 3);                     // R2
    compare(2, 5);                     // R3
    cur_hi = 1; compare(1, 1); compare(2, 2); cur_hi = 0;  // R7
    compare(0, 0);                     // R4
    pump_off = 1; compare(1, 6); compare(2, 4); pump_off = 0;  // R5
    compare(1, 9);                     // R11 staggered rises everywhere

    compare(2, 4);
    for (int i = 0; i < 7; i++) compare(0, 0);
    check("R9 not yet locked", locked, 0);
    compare(1, 1);
    check("R9 locked", locked, 1);
    compare(0, 0);
    check("R9 stays locked", locked, 1);
    compare(2, 2);
    check("R10 lock lost", locked, 0);

    repeat (4) @(negedge clk);
    check("R2/R3 pending expectations", exp_q.size(), 0);
    report();
  end
endmodule